// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration header of a PCI-style function as 64 registers of 32 bits. A host port writes a byte, a 16-bit word or a full dword, addressed by register index and byte offset inside the register. A separate host read port returns a whole dword one clock after the request. Every register has a fixed writable-bit mask. A host write changes only the bits that are both in the written lanes and in that mask; all other bits keep their value.

Identity values (vendor, device, class triple and subsystem pair) and a header-type selector are parameters. They set the reset contents and pick the mask set: an endpoint header or a bridge header. A second, privileged write port carries single bytes from on-chip setup logic. It ignores the masks, so it can fill read-only fields such as status bits or capability bytes. The bus protocol layer sits outside this block.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, register 0 reads {DEVICE_ID, VENDOR_ID} (device in bits 31:16), register 2 reads {CLASS_CODE, SUBCLASS, PROG_IF, 8'h00} (class in bits 31:24), register 11 reads {SUBSYS_ID, SUBSYS_VENDOR_ID} (subsystem ID in bits 31:16), and every other endpoint register reads 0.
- R2: A read with `host_re` high returns the addressed register on `host_rdata` after the next rising edge. It returns 32'hFFFF_FFFF when the index is 64 or more. `host_rdata` holds its value while `host_re` is low.
- R3: Host writes of any width never change register 0.
- R4: Register 1 has writable mask 32'h0000_FFFF: its low half takes host data and its high half ignores host writes.
- R5: On an endpoint header, registers 3 and 15 both have writable mask 32'h0000_00FF, and registers without a listed mask (for example 9) ignore host writes.
- R6: A host write updates the register as (old & ~m) | (new & m), where m is the writable mask restricted to the written lanes. `host_size` encodes 0 = byte, 1 = word, 2 = dword. Write data sits in the low bits of `host_wdata`, and byte lane k covers bits 8k+7:8k.
- R7: A word write is accepted only at byte offset 0 or 2. A word write at offset 1 or 3 changes nothing.
- R8: A dword write with a nonzero offset, a write with `host_size` = 3, and a write to an index of 64 or more all change nothing.
- R9: The setup port writes byte `setup_wdata` at byte address `setup_addr` (register = addr[7:2], lane = addr[1:0]) regardless of the writable masks.
- R10: When a host write and a setup write hit the same byte in the same cycle, the setup byte wins. The host still writes its other lanes.
- R11: A read issued in the same cycle as a write to the same register returns the value from before that write.
- R12: With HEADER_BRIDGE = 1, register 3 resets to 32'h0001_0000, register 9 has mask 32'hFFF0_FFF0, and register 15 has mask 32'hFFFF_00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write request |
| host_idx | input | 8 | Host write register index |
| host_off | input | 2 | Byte offset inside the register |
| host_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| host_wdata | input | 32 | Write data, right-aligned |
| host_re | input | 1 | Host read request |
| host_ridx | input | 8 | Host read register index |
| host_rdata | output | 32 | Registered read data |
| setup_we | input | 1 | Privileged byte write |
| setup_addr | input | 8 | Privileged byte address |
| setup_wdata | input | 8 | Privileged byte data |

## Verification
The bench drives word writes at odd offsets and dword writes at offsets 2 and 1. A decoder that does not reject them would smear data into the wrong lanes of the control register. Writes to index 65 would land in register 1 if the index were truncated instead of range-checked.

A read beyond register 63 must give all ones, not a wrapped register. A same-cycle host and setup write to one byte of register 1 exposes a wrong priority: the host byte would survive. A same-cycle read and write exposes a read mux that looks at the next value instead of the stored one. A bridge instance runs next to the endpoint instance and shows whether the header selector really swaps the masks of registers 3, 9 and 15.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } xfer_size_e;

  // alignment rule for a host write
  function automatic logic align_ok(xfer_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE:  return 1'b1;
      SZ_WORD:  return (off[0] == 1'b0);
      SZ_DWORD: return (off == 2'd0);
      default:  return 1'b0;
    endcase
  endfunction

  // byte lanes touched by a write
  function automatic logic [LANES-1:0] lane_sel(xfer_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE:  return LANES'(4'b0001 << off);
      SZ_WORD:  return off[1] ? 4'b1100 : 4'b0011;
      SZ_DWORD: return 4'b1111;
      default:  return 4'b0000;
    endcase
  endfunction

  // expand lane enables to a bit mask
  function automatic logic [DW-1:0] lanes_to_bits(logic [LANES-1:0] l);
    logic [DW-1:0] b;
    for (int i = 0; i < LANES; i++) b[i*8 +: 8] = {8{l[i]}};
    return b;
  endfunction

  // move right-aligned data into its lanes
  function automatic logic [DW-1:0] place_data(xfer_size_e sz, logic [1:0] off,
                                                logic [DW-1:0] d);
    logic [4:0] sh;
    sh = {off, 3'b000};
    case (sz)
      SZ_BYTE:  return {24'h0, d[7:0]} << sh;
      SZ_WORD:  return {16'h0, d[15:0]} << sh;
      default:  return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_v, logic [DW-1:0] new_v,
                                           logic [DW-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // host-writable bits per register, chosen by header kind
  function automatic logic [DW-1:0] wmask_for(int idx, logic bridge);
    case (idx)
      1:       return 32'h0000_FFFF;
      3:       return 32'h0000_00FF;
      9:       return bridge ? 32'hFFF0_FFF0 : 32'h0000_0000;
      15:      return bridge ? 32'hFFFF_00FF : 32'h0000_00FF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // contents loaded at reset
  function automatic logic [DW-1:0] init_for(int idx, logic bridge,
      logic [15:0] vid, logic [15:0] did, logic [7:0] cls, logic [7:0] sub,
      logic [7:0] pif, logic [15:0] ssvid, logic [15:0] ssid);
    case (idx)
      0:       return {did, vid};
      2:       return {cls, sub, pif, 8'h00};
      3:       return bridge ? 32'h0001_0000 : 32'h0000_0000;
      11:      return {ssid, ssvid};
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_host_decode.sv
module cfg_host_decode
  import cfgspace_pkg::*;
#(
  parameter int NUM_REGS   = 64,
  parameter int HOST_IDX_W = 8,
  localparam int RIW       = $clog2(NUM_REGS)
) (
  input  logic                  host_we,
  input  logic [HOST_IDX_W-1:0] host_idx,
  input  logic [1:0]            host_off,
  input  logic [1:0]            host_size,
  input  logic [DW-1:0]         host_wdata,
  output logic                  commit,
  output logic [RIW-1:0]        tgt_idx,
  output logic [LANES-1:0]      lanes,
  output logic [DW-1:0]         lane_bits,
  output logic [DW-1:0]         wdata_al
);
  xfer_size_e sz;
  logic       in_range;

  assign sz        = xfer_size_e'(host_size);
  assign in_range  = 32'(host_idx) < NUM_REGS;
  assign commit    = host_we && in_range && align_ok(sz, host_off);
  assign tgt_idx   = host_idx[RIW-1:0];
  assign lanes     = commit ? lane_sel(sz, host_off) : '0;
  assign lane_bits = lanes_to_bits(lanes);
  assign wdata_al  = place_data(sz, host_off, host_wdata);
endmodule

// File: rtl/cfg_setup_decode.sv
module cfg_setup_decode
  import cfgspace_pkg::*;
#(
  parameter int NUM_REGS = 64,
  localparam int RIW     = $clog2(NUM_REGS)
) (
  input  logic             setup_we,
  input  logic [RIW+1:0]   setup_addr,
  input  logic [7:0]       setup_wdata,
  output logic             hit,
  output logic [RIW-1:0]   tgt_idx,
  output logic [DW-1:0]    lane_bits,
  output logic [DW-1:0]    wdata_al
);
  assign hit       = setup_we;
  assign tgt_idx   = setup_addr[RIW+1:2];
  assign lane_bits = setup_we ? lanes_to_bits(LANES'(4'b0001 << setup_addr[1:0])) : '0;
  assign wdata_al  = {LANES{setup_wdata}};
endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array
  import cfgspace_pkg::*;
#(
  parameter int          NUM_REGS         = 64,
  parameter logic        HEADER_BRIDGE    = 1'b0,
  parameter logic [15:0] VENDOR_ID        = 16'h1234,
  parameter logic [15:0] DEVICE_ID        = 16'h5678,
  parameter logic [7:0]  CLASS_CODE       = 8'h04,
  parameter logic [7:0]  SUBCLASS         = 8'h01,
  parameter logic [7:0]  PROG_IF          = 8'h5A,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'hABCD,
  parameter logic [15:0] SUBSYS_ID        = 16'h2468,
  localparam int RIW = $clog2(NUM_REGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_commit,
  input  logic [RIW-1:0] h_idx,
  input  logic [DW-1:0]  h_bits,
  input  logic [DW-1:0]  h_data,
  input  logic           s_hit,
  input  logic [RIW-1:0] s_idx,
  input  logic [DW-1:0]  s_bits,
  input  logic [DW-1:0]  s_data,
  output logic [DW-1:0]  regs_q [NUM_REGS]
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [DW-1:0] WMASK = wmask_for(r, HEADER_BRIDGE);
    localparam logic [DW-1:0] INIT  = init_for(r, HEADER_BRIDGE, VENDOR_ID, DEVICE_ID,
                                               CLASS_CODE, SUBCLASS, PROG_IF,
                                               SUBSYS_VENDOR_ID, SUBSYS_ID);
    logic [DW-1:0] q, hmask, smask, nxt;

    always_comb begin
      hmask = (h_commit && h_idx == RIW'(r)) ? (h_bits & WMASK) : '0;
      smask = (s_hit && s_idx == RIW'(r)) ? s_bits : '0;
      nxt   = merge(merge(q, h_data, hmask & ~smask), s_data, smask);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= INIT;
      else        q <= nxt;
    end

    assign regs_q[r] = q;
  end
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import cfgspace_pkg::*;
#(
  parameter int NUM_REGS   = 64,
  parameter int HOST_IDX_W = 8,
  localparam int RIW       = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_re,
  input  logic [HOST_IDX_W-1:0] host_ridx,
  input  logic [DW-1:0]         regs_q [NUM_REGS],
  output logic [DW-1:0]         host_rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    if (32'(host_ridx) < NUM_REGS) sel = regs_q[host_ridx[RIW-1:0]];
    else                           sel = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_re) host_rdata <= sel;
  end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfgspace_pkg::*;
#(
  parameter int          NUM_REGS         = 64,
  parameter int          HOST_IDX_W       = 8,
  parameter logic        HEADER_BRIDGE    = 1'b0,
  parameter logic [15:0] VENDOR_ID        = 16'h1234,
  parameter logic [15:0] DEVICE_ID        = 16'h5678,
  parameter logic [7:0]  CLASS_CODE       = 8'h04,
  parameter logic [7:0]  SUBCLASS         = 8'h01,
  parameter logic [7:0]  PROG_IF          = 8'h5A,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'hABCD,
  parameter logic [15:0] SUBSYS_ID        = 16'h2468
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_we,
  input  logic [HOST_IDX_W-1:0]         host_idx,
  input  logic [1:0]                    host_off,
  input  logic [1:0]                    host_size,
  input  logic [31:0]                   host_wdata,
  input  logic                          host_re,
  input  logic [HOST_IDX_W-1:0]         host_ridx,
  output logic [31:0]                   host_rdata,
  input  logic                          setup_we,
  input  logic [$clog2(NUM_REGS)+1:0]   setup_addr,
  input  logic [7:0]                    setup_wdata
);
  localparam int RIW = $clog2(NUM_REGS);

  // named internal events, visible to the bound checker
  logic             host_commit;
  logic [RIW-1:0]   host_tgt;
  logic [LANES-1:0] host_lanes;
  logic [DW-1:0]    host_bits, host_al;
  logic             setup_hit;
  logic [RIW-1:0]   setup_tgt;
  logic [DW-1:0]    setup_bits, setup_al;
  logic [DW-1:0]    regs_q [NUM_REGS];

  cfg_host_decode #(.NUM_REGS(NUM_REGS), .HOST_IDX_W(HOST_IDX_W)) u_hdec (
    .host_we(host_we), .host_idx(host_idx), .host_off(host_off),
    .host_size(host_size), .host_wdata(host_wdata),
    .commit(host_commit), .tgt_idx(host_tgt), .lanes(host_lanes),
    .lane_bits(host_bits), .wdata_al(host_al)
  );

  cfg_setup_decode #(.NUM_REGS(NUM_REGS)) u_sdec (
    .setup_we(setup_we), .setup_addr(setup_addr), .setup_wdata(setup_wdata),
    .hit(setup_hit), .tgt_idx(setup_tgt), .lane_bits(setup_bits),
    .wdata_al(setup_al)
  );

  cfg_reg_array #(
    .NUM_REGS(NUM_REGS), .HEADER_BRIDGE(HEADER_BRIDGE),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .SUBCLASS(SUBCLASS), .PROG_IF(PROG_IF),
    .SUBSYS_VENDOR_ID(SUBSYS_VENDOR_ID), .SUBSYS_ID(SUBSYS_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .h_commit(host_commit), .h_idx(host_tgt), .h_bits(host_bits), .h_data(host_al),
    .s_hit(setup_hit), .s_idx(setup_tgt), .s_bits(setup_bits), .s_data(setup_al),
    .regs_q(regs_q)
  );

  cfg_read_port #(.NUM_REGS(NUM_REGS), .HOST_IDX_W(HOST_IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .host_re(host_re), .host_ridx(host_ridx),
    .regs_q(regs_q), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
  parameter int NUM_REGS   = 64,
  parameter int HOST_IDX_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_we,
  input logic [HOST_IDX_W-1:0] host_idx,
  input logic [1:0]            host_off,
  input logic [1:0]            host_size,
  input logic                  host_re,
  input logic [HOST_IDX_W-1:0] host_ridx,
  input logic [31:0]           host_rdata,
  input logic                  setup_we,
  input logic                  host_commit,
  input logic [3:0]            host_lanes,
  input logic [31:0]           id_reg,
  input logic [31:0]           ctl_reg
);
  AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_we |=> $stable(id_reg)); // R3

  AST_STATUS_HALF_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_we |=> $stable(ctl_reg[31:16])); // R4

  AST_WORD_ODD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_size == 2'd1 && host_off[0]) |-> !host_commit); // R7

  AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && (host_size == 2'd3 || (host_size == 2'd2 && host_off != 2'd0)))
      |-> !host_commit); // R8

  AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    host_commit |-> (32'(host_idx) < NUM_REGS)); // R8

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_commit && host_size == 2'd0) |-> $countones(host_lanes) == 1); // R6

  AST_OOR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && 32'(host_ridx) >= NUM_REGS) |=> host_rdata == 32'hFFFF_FFFF); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(host_rdata)); // R2
endmodule

bind cfg_space_regfile cfg_space_checker #(.NUM_REGS(NUM_REGS), .HOST_IDX_W(HOST_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
  .host_off(host_off), .host_size(host_size), .host_re(host_re),
  .host_ridx(host_ridx), .host_rdata(host_rdata), .setup_we(setup_we),
  .host_commit(host_commit), .host_lanes(host_lanes),
  .id_reg(regs_q[0]), .ctl_reg(regs_q[1])
);

// File: tb/cfg_space_regfile_test.sv
module cfg_space_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_idx = '0;
  logic [1:0]  host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_re = 1'b0;
  logic [7:0]  host_ridx = '0;
  logic        setup_we = 1'b0;
  logic [7:0]  setup_addr = '0;
  logic [7:0]  setup_wdata = '0;
  logic [31:0] rd_dev, rd_br;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  cfg_space_regfile #(.HEADER_BRIDGE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_re(host_re), .host_ridx(host_ridx), .host_rdata(rd_dev),
    .setup_we(setup_we), .setup_addr(setup_addr), .setup_wdata(setup_wdata)
  );

  cfg_space_regfile #(.HEADER_BRIDGE(1'b1)) uut_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_re(host_re), .host_ridx(host_ridx), .host_rdata(rd_br),
    .setup_we(setup_we), .setup_addr(setup_addr), .setup_wdata(setup_wdata)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one cycle of stimulus; read data is sampled after the edge
  task automatic cycle(bit hwe, logic [1:0] sz, logic [7:0] idx, logic [1:0] off,
                       logic [31:0] d, bit swe, logic [7:0] sa, logic [7:0] sd,
                       bit re, logic [7:0] ridx);
    @(negedge clk);
    host_we = hwe; host_size = sz; host_idx = idx; host_off = off; host_wdata = d;
    setup_we = swe; setup_addr = sa; setup_wdata = sd;
    host_re = re; host_ridx = ridx;
    @(negedge clk);
    host_we = 1'b0; setup_we = 1'b0; host_re = 1'b0;
  endtask

  task automatic hwr(logic [1:0] sz, logic [7:0] idx, logic [1:0] off, logic [31:0] d);
    cycle(1'b1, sz, idx, off, d, 1'b0, 8'h0, 8'h0, 1'b0, 8'h0);
  endtask

  task automatic swr(logic [7:0] a, logic [7:0] d);
    cycle(1'b0, 2'd0, 8'h0, 2'd0, 32'h0, 1'b1, a, d, 1'b0, 8'h0);
  endtask

  task automatic rd(logic [7:0] idx);
    cycle(1'b0, 2'd0, 8'h0, 2'd0, 32'h0, 1'b0, 8'h0, 8'h0, 1'b1, idx);
  endtask

  task automatic t_reset;
    check("R2 rdata at reset", rd_dev, 32'h0);
    rd(8'd0);  check("R1 reg0", rd_dev, 32'h5678_1234);
    rd(8'd2);  check("R1 reg2", rd_dev, 32'h0401_5A00);
    rd(8'd11); check("R1 reg11", rd_dev, 32'h2468_ABCD);
    rd(8'd3);  check("R1 reg3 device", rd_dev, 32'h0);
               check("R12 reg3 bridge", rd_br, 32'h0001_0000);
    rd(8'd5);  check("R1 reg5", rd_dev, 32'h0);
  endtask

  task automatic t_oor_read;
    rd(8'd64);  check("R2 idx64", rd_dev, 32'hFFFF_FFFF);
    rd(8'd255); check("R2 idx255", rd_dev, 32'hFFFF_FFFF);
    cycle(1'b0, 2'd0, 8'h0, 2'd0, 32'h0, 1'b0, 8'h0, 8'h0, 1'b0, 8'd0);
    check("R2 hold when idle", rd_dev, 32'hFFFF_FFFF);
  endtask

  task automatic t_masks;
    hwr(2'd2, 8'd0, 2'd0, 32'hFFFF_FFFF);
    rd(8'd0);  check("R3 reg0 locked", rd_dev, 32'h5678_1234);
    hwr(2'd2, 8'd1, 2'd0, 32'hFFFF_FFFF);
    rd(8'd1);  check("R4 reg1 mask", rd_dev, 32'h0000_FFFF);
    hwr(2'd2, 8'd3, 2'd0, 32'hFFFF_FFFF);
    rd(8'd3);  check("R5 reg3 mask", rd_dev, 32'h0000_00FF);
               check("R12 reg3 bridge", rd_br, 32'h0001_00FF);
    hwr(2'd2, 8'd15, 2'd0, 32'hFFFF_FFFF);
    rd(8'd15); check("R5 reg15 device", rd_dev, 32'h0000_00FF);
               check("R12 reg15 bridge", rd_br, 32'hFFFF_00FF);
    hwr(2'd2, 8'd9, 2'd0, 32'hFFFF_FFFF);
    rd(8'd9);  check("R5 reg9 device", rd_dev, 32'h0);
               check("R12 reg9 bridge", rd_br, 32'hFFF0_FFF0);
  endtask

  task automatic t_bytes;
    hwr(2'd0, 8'd1, 2'd1, 32'h0000_00AB);
    rd(8'd1);  check("R6 byte lane1", rd_dev, 32'h0000_ABFF);
    hwr(2'd0, 8'd1, 2'd0, 32'hFFFF_FF12);
    rd(8'd1);  check("R6 byte lane0", rd_dev, 32'h0000_AB12);
    hwr(2'd0, 8'd1, 2'd2, 32'h0000_0077);
    rd(8'd1);  check("R4 status byte", rd_dev, 32'h0000_AB12);
  endtask

  task automatic t_words;
    hwr(2'd1, 8'd1, 2'd2, 32'h0000_5555);
    rd(8'd1);  check("R4 status word", rd_dev, 32'h0000_AB12);
    hwr(2'd1, 8'd1, 2'd0, 32'h0000_3C3C);
    rd(8'd1);  check("R6 word low", rd_dev, 32'h0000_3C3C);
    hwr(2'd1, 8'd1, 2'd1, 32'h0000_0000);
    rd(8'd1);  check("R7 word off1", rd_dev, 32'h0000_3C3C);
    hwr(2'd1, 8'd1, 2'd3, 32'h0000_0000);
    rd(8'd1);  check("R7 word off3", rd_dev, 32'h0000_3C3C);
  endtask

  task automatic t_drops;
    hwr(2'd2, 8'd1, 2'd2, 32'h0);
    rd(8'd1);  check("R8 dword off2", rd_dev, 32'h0000_3C3C);
    hwr(2'd2, 8'd1, 2'd1, 32'h0);
    rd(8'd1);  check("R8 dword off1", rd_dev, 32'h0000_3C3C);
    hwr(2'd3, 8'd1, 2'd0, 32'h0);
    rd(8'd1);  check("R8 size3", rd_dev, 32'h0000_3C3C);
    hwr(2'd2, 8'd65, 2'd0, 32'h0);
    rd(8'd1);  check("R8 idx65", rd_dev, 32'h0000_3C3C);
  endtask

  task automatic t_setup;
    swr(8'h01, 8'hEE);
    rd(8'd0);  check("R9 setup reg0", rd_dev, 32'h5678_EE34);
    swr(8'h0A, 8'h99);
    rd(8'd2);  check("R9 setup reg2", rd_dev, 32'h0499_5A00);
    cycle(1'b1, 2'd2, 8'd1, 2'd0, 32'h0000_1111, 1'b1, 8'h04, 8'hAA, 1'b0, 8'h0);
    rd(8'd1);  check("R10 setup wins", rd_dev, 32'h0000_11AA);
    swr(8'h06, 8'h10);
    rd(8'd1);  check("R9 setup status", rd_dev, 32'h0010_11AA);
    hwr(2'd2, 8'd1, 2'd0, 32'h0);
    rd(8'd1);  check("R4 status kept", rd_dev, 32'h0010_0000);
  endtask

  task automatic t_rw_same;
    cycle(1'b1, 2'd0, 8'd3, 2'd0, 32'h0000_0042, 1'b0, 8'h0, 8'h0, 1'b1, 8'd3);
    check("R11 old value", rd_dev, 32'h0000_00FF);
    rd(8'd3);  check("R11 new value", rd_dev, 32'h0000_0042);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oor_read();
    t_masks();
    t_bytes();
    t_words();
    t_drops();
    t_setup();
    t_rw_same();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule